// File: doc/BRIEF.md
# Fair Five-Way Bus Arbiter

This block shares one bus among five requesters and drives a single registered one-hot grant vector. Each requester raises its request bit to ask for the bus. A requester may also raise an interrupt bit, which takes the bus at the next clock edge no matter who holds it. Once a requester holds the bus it keeps it while its request stays high. Two fairness controls can shorten that tenure. With the tenure cap on, requester *i* loses the bus after *i* consecutive cycles. In least-recently-used mode, a tie between competing requests goes to the requester that was served longest ago.

Two static control inputs set the behaviour: `lru_mode_i` chooses between fixed priority and LRU tie-breaking, and `cap_en_i` turns the tenure cap on or off. With both low, the arbiter gives the baseline behaviour of lowest index first, with an unlimited hold. All buses are plain level signals with no handshake: a request is a request, a grant is a grant.

Top module: `fair_bus_arbiter`

## Requirements
- R1: While `rst_n` is low, and in the first cycle after it, `grant_o` is all zero. Reset also sets the LRU ranking to requester 1 oldest, then 2, 3 and 4, with requester 5 newest.
- R2: At most one bit of `grant_o` is high in any cycle. Bit k-1 of `req_i`, `intr_i` and `grant_o` belongs to requester k. Grants are registered: a decision taken from the inputs at one rising edge appears on `grant_o` right after that edge.
- R3: With `lru_mode_i` low, arbitration picks the lowest-indexed pending request.
- R4: With no interrupt pending and the cap either off or not yet reached, the current owner keeps its grant while its request stays high.
- R5: With `cap_en_i` high, requester k holds a grant for at most k consecutive cycles. When the cap is reached and no other request is pending, a requester that still requests is granted again as a new grant, and its count restarts.
- R6: With `cap_en_i` high, an owner that reaches its cap while others request loses the bus to one of the others, even if its own request is still high.
- R7: With `lru_mode_i` high, arbitration picks the pending requester that was granted least recently. Every new grant, including one caused by an interrupt and including one made in fixed mode, makes the winner the most recently used.
- R8: A high interrupt bit gives that requester the grant at the next edge, whether or not it requests and whoever owns the bus. This counts as a new grant.
- R9: When several interrupt bits are high together, the lowest index wins.
- R10: When the owner drops its request or hits its cap and another request is pending, the next grant follows with no idle cycle.
- R11: When no request and no interrupt is present, `grant_o` returns to all zero at the next edge.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Rising-edge clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| lru_mode_i | input | 1 | Static: 1 selects LRU tie-break, 0 selects fixed priority |
| cap_en_i | input | 1 | Static: 1 enables the per-requester tenure cap |
| req_i | input | 5 | Request bits, bit k-1 for requester k |
| intr_i | input | 5 | Interrupt bits, bit k-1 for requester k |
| grant_o | output | 5 | Registered one-hot grant, bit k-1 for requester k |

## Verification
A corrupted LRU ranking shows up only when two or more requests compete for the bus. At that point the grant goes to the wrong requester, one cycle after the decision edge. For this reason the bench runs long stretches of dense, overlapping requests in LRU mode. A wrong tenure count shows as a grant that ends one cycle early or late, which a cycle-exact reference model catches within the first capped grant. An error in owner tracking shows as a second grant bit, or as a lost hold, on the very next edge.

// File: rtl/fba_pkg.sv
package fba_pkg;
  // Kind of decision taken by the arbiter in one cycle.
  typedef enum logic [1:0] {
    DEC_IDLE = 2'd0,
    DEC_KEEP = 2'd1,
    DEC_ARB  = 2'd2,
    DEC_INTR = 2'd3
  } dec_e;
endpackage

// File: rtl/fba_lru_rank.sv
module fba_lru_rank #(
  parameter int N  = 5,
  parameter int RW = 3
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 upd,
  input  logic [N-1:0]         upd_oh,
  output logic [N-1:0][RW-1:0] rank_o
);
  // rank 0 is oldest, N-1 is newest
  localparam logic [RW-1:0] TOP = RW'(N - 1);

  logic [RW-1:0] win_rank;

  always_comb begin
    win_rank = '0;
    for (int k = 0; k < N; k++)
      if (upd_oh[k]) win_rank = win_rank | rank_o[k];
  end

  for (genvar k = 0; k < N; k++) begin : g_slot
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
        rank_o[k] <= RW'(k);
      else if (upd) begin
        if (upd_oh[k])
          rank_o[k] <= TOP;
        else if (rank_o[k] > win_rank)
          rank_o[k] <= rank_o[k] - RW'(1);
      end
    end

    // R7: a fresh winner is the newest entry on the following cycle
    a_r7_newest_after_grant: assert property (@(posedge clk) disable iff (!rst_n)
      (upd && upd_oh[k]) |=> (rank_o[k] == TOP));
  end
endmodule

// File: rtl/fba_tenure_ctr.sv
module fba_tenure_ctr #(
  parameter int CW = 3
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          start,
  input  logic          keep,
  output logic [CW-1:0] cnt_o
);
  localparam logic [CW-1:0] CMAX = '1;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)
      cnt_o <= '0;
    else if (start)
      cnt_o <= CW'(1);
    else if (keep) begin
      if (cnt_o != CMAX) cnt_o <= cnt_o + CW'(1);
    end else
      cnt_o <= '0;
  end

  // R5: every new grant restarts the tenure at one cycle
  a_r5_restart: assert property (@(posedge clk) disable iff (!rst_n)
    start |=> (cnt_o == CW'(1)));
endmodule

// File: rtl/fba_winner_sel.sv
module fba_winner_sel #(
  parameter int N  = 5,
  parameter int RW = 3
) (
  input  logic [N-1:0]         cand,
  input  logic                 lru_mode,
  input  logic [N-1:0][RW-1:0] rank,
  output logic [N-1:0]         win_oh
);
  logic [N-1:0]  fix_oh;
  logic [N-1:0]  lru_oh;
  logic [RW-1:0] best;
  logic          found;

  // lowest index among candidates
  always_comb begin
    fix_oh = '0;
    for (int k = N - 1; k >= 0; k--)
      if (cand[k]) fix_oh = N'(1) << k;
  end

  // oldest rank among candidates
  always_comb begin
    lru_oh = '0;
    best   = '1;
    found  = 1'b0;
    for (int k = 0; k < N; k++) begin
      if (cand[k] && (!found || rank[k] < best)) begin
        best   = rank[k];
        lru_oh = N'(1) << k;
        found  = 1'b1;
      end
    end
  end

  assign win_oh = lru_mode ? lru_oh : fix_oh;
endmodule

// File: rtl/fair_bus_arbiter.sv
module fair_bus_arbiter #(
  parameter int N  = 5,
  parameter int CW = 3
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         lru_mode_i,
  input  logic         cap_en_i,
  input  logic [N-1:0] req_i,
  input  logic [N-1:0] intr_i,
  output logic [N-1:0] grant_o
);
  import fba_pkg::*;

  localparam int IW = (N > 1) ? $clog2(N) : 1;
  localparam int RW = IW;

  logic [N-1:0]         grant_q, grant_d, intr_oh, others, cand, win_oh;
  logic [N-1:0][RW-1:0] rank;
  logic [IW-1:0]        own_idx;
  logic [CW-1:0]        cnt, cap_lim;
  logic                 busy, owner_req, cap_hit, keep, start;
  dec_e                 dec;

  always_comb begin
    own_idx = '0;
    for (int k = 0; k < N; k++)
      if (grant_q[k]) own_idx = IW'(k);
  end

  assign busy      = |grant_q;
  assign owner_req = |(grant_q & req_i);
  assign cap_lim   = CW'(own_idx) + CW'(1);
  assign cap_hit   = cap_en_i && busy && (cnt == cap_lim);
  assign intr_oh   = intr_i & (~intr_i + N'(1));
  assign others    = req_i & ~grant_q;
  // a capped owner steps aside only when someone else is waiting
  assign cand      = (owner_req && cap_hit && |others) ? others : req_i;

  fba_winner_sel #(.N(N), .RW(RW)) u_sel (
    .cand     (cand),
    .lru_mode (lru_mode_i),
    .rank     (rank),
    .win_oh   (win_oh)
  );

  always_comb begin
    if (|intr_i)                  dec = DEC_INTR;
    else if (owner_req && !cap_hit) dec = DEC_KEEP;
    else if (|win_oh)             dec = DEC_ARB;
    else                          dec = DEC_IDLE;
  end

  always_comb begin
    unique case (dec)
      DEC_INTR: grant_d = intr_oh;
      DEC_KEEP: grant_d = grant_q;
      DEC_ARB:  grant_d = win_oh;
      default:  grant_d = '0;
    endcase
  end

  assign keep  = (dec == DEC_KEEP);
  assign start = (dec == DEC_INTR) || (dec == DEC_ARB);

  fba_tenure_ctr #(.CW(CW)) u_ten (
    .clk   (clk),
    .rst_n (rst_n),
    .start (start),
    .keep  (keep),
    .cnt_o (cnt)
  );

  fba_lru_rank #(.N(N), .RW(RW)) u_lru (
    .clk    (clk),
    .rst_n  (rst_n),
    .upd    (start),
    .upd_oh (grant_d),
    .rank_o (rank)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) grant_q <= '0;
    else        grant_q <= grant_d;
  end

  assign grant_o = grant_q;

  // R2: never more than one owner
  a_r2_onehot: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(grant_q));

  // R9: interrupt winner is a raised interrupt with none raised below it
  a_r9_lowest_intr: assert property (@(posedge clk) disable iff (!rst_n)
    (|intr_i) |=> (((grant_q & $past(intr_i)) != '0) &&
                   (((grant_q - N'(1)) & $past(intr_i)) == '0)));

  // R5: tenure counter never passes the owner's cap
  a_r5_cap_bound: assert property (@(posedge clk) disable iff (!rst_n)
    (cap_en_i && busy) |-> (cnt <= cap_lim));

  // R4: uncapped owner that still requests is kept
  a_r4_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (!cap_en_i && owner_req && !(|intr_i)) |=> $stable(grant_q));

  // R10: any pending request yields a grant on the next edge
  a_r10_no_gap: assert property (@(posedge clk) disable iff (!rst_n)
    ((|req_i) && !(|intr_i)) |=> busy);

  // R11: nothing pending leaves the bus idle
  a_r11_release: assert property (@(posedge clk) disable iff (!rst_n)
    (!(|req_i) && !(|intr_i)) |=> !busy);
endmodule

// File: tb/test_fair_bus_arbiter.sv
`timescale 1ns/1ps
module test_fair_bus_arbiter;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       lru_mode = 1'b0;
  logic       cap_en = 1'b0;
  logic [4:0] req = '0;
  logic [4:0] intr = '0;
  logic [4:0] grant;

  int checks = 0;
  int failures = 0;
  bit done = 1'b0;

  always #2.5 clk = ~clk;

  fair_bus_arbiter i_fair_bus_arbiter (
    .clk(clk), .rst_n(rst_n), .lru_mode_i(lru_mode), .cap_en_i(cap_en),
    .req_i(req), .intr_i(intr), .grant_o(grant)
  );

  // behavioural reference
  int    owner = -1;
  int    held = 0;
  int    order[$];
  string why = "R1";

  function automatic int lowest(input logic [4:0] v);
    for (int k = 0; k < 5; k++) if (v[k]) return k;
    return -1;
  endfunction

  task automatic give(input int w);
    owner = w;
    held = 1;
    for (int k = 0; k < order.size(); k++)
      if (order[k] == w) begin order.delete(k); break; end
    order.push_back(w);
  endtask

  always @(posedge clk) begin
    if (!rst_n) begin
      owner = -1; held = 0; why = "R1";
      order = {0, 1, 2, 3, 4};
    end else if (intr != 0) begin
      why = ($countones(intr) > 1) ? "R9" : "R8";
      give(lowest(intr));
    end else if (owner >= 0 && req[owner] && !(cap_en && held == owner + 1)) begin
      why = "R4";
      if (held < 7) held++;
    end else begin
      logic [4:0] pool;
      bit capped;
      int w;
      pool = req;
      capped = (owner >= 0) && req[owner];
      if (capped && (req & ~(5'b1 << owner)) != 0) pool[owner] = 1'b0;
      if (pool == 0) begin
        owner = -1; held = 0; why = "R11";
      end else begin
        w = -1;
        if (!lru_mode) w = lowest(pool);
        else foreach (order[k]) if (w < 0 && pool[order[k]]) w = order[k];
        if (capped) why = (pool[owner]) ? "R5" : "R6";
        else if (owner >= 0) why = "R10";
        else why = lru_mode ? "R7" : "R3";
        give(w);
      end
    end
  end

  task automatic compare();
    logic [4:0] exp;
    exp = (owner >= 0) ? (5'b1 << owner) : 5'b0;
    checks++;
    if (grant !== exp) begin
      failures++;
      $display("FAIL %s grant actual=%b expected=%b at %0t", why, grant, exp, $time);
    end
    checks++;
    if ($countones(grant) > 1) begin
      failures++;
      $display("FAIL R2 onehot actual=%b expected=at most one bit", grant);
    end
  endtask

  task automatic step(input logic [4:0] r, input logic [4:0] it);
    @(negedge clk);
    compare();
    req = r;
    intr = it;
  endtask

  task automatic restart(input bit lm, input bit ce);
    @(negedge clk);
    rst_n = 1'b0; req = '0; intr = '0; lru_mode = lm; cap_en = ce;
    step(0, 0);
    step(0, 0);
    rst_n = 1'b1;
  endtask

  initial begin
    // R1 reset state, fixed priority without cap
    restart(0, 0);
    step(5'b00110, 0); step(5'b00110, 0); step(5'b00110, 0);   // R3 R4
    step(5'b00100, 0); step(5'b00100, 0);                      // R10
    step(5'b00000, 0); step(5'b11111, 0); step(5'b11111, 0);   // R11 R3
    // R5 R6 cap in fixed mode
    restart(0, 1);
    for (int n = 0; n < 10; n++) step(5'b11111, 0);
    for (int n = 0; n < 4; n++)  step(5'b00001, 0);
    for (int n = 0; n < 8; n++)  step(5'b10000, 0);
    // R7 LRU mode
    restart(1, 0);
    step(5'b11000, 0); step(5'b00000, 0);
    for (int n = 0; n < 6; n++) step(5'b11111, 0);
    restart(1, 1);
    for (int n = 0; n < 20; n++) step(5'b11111, 0);
    // R8 R9 interrupts
    step(5'b00011, 5'b01100); step(5'b00011, 0);
    step(5'b00001, 5'b10000); step(5'b00000, 0); step(5'b00000, 0);
    // mixed traffic in every mode pair
    for (int m = 0; m < 4; m++) begin
      restart(m[0], m[1]);
      for (int n = 0; n < 500; n++) begin
        logic [4:0] r, it;
        r  = 5'($urandom) | 5'($urandom);
        it = (($urandom % 8) == 0) ? 5'($urandom) & 5'($urandom) : 5'b0;
        step(r, it);
      end
    end
    step(0, 0); step(0, 0);
    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    #200000;
    if (!done) begin
      checks++;
      failures++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end
endmodule